// File: doc/BRIEF.md
# Split-Word GPIO Controller with Edge Interrupts

This block serves 32 general-purpose pins through a register window that is sixteen bits wide. Each 32-bit register is reached as two halves: the low half at a base offset and the high half 0x500 above it. The pin levels pass through a two-stage synchroniser and are latched into an input-state register. Each pin can raise the interrupt on a rising edge, on a falling edge, or on both, and a status register records which single pin caused the most recent event.

Two fixed groups of output bits also drive other logic on the chip. Output bits 29 and 30 drive a bit-banged I2C data and clock line. A 3-bit backlight level is decoded through a fixed code table from output bits [18:16] together with three output-enable bits. The interrupt is a level that stays high until the acknowledge input clears it.

Top module: `gpio_split_edge`

## Requirements
- R1: After reset the input register reads all ones, output, rising mask, falling mask and status read zero, the interrupt is low and the backlight level is 7.
- R2: Register offsets (low half / high half) are output 0x00C/0x50C, input 0x010/0x510, falling mask 0x014/0x514, rising mask 0x018/0x518 and status 0x020/0x520. A low-half write changes only bits [15:0], a high-half write changes only bits [31:16], and a read returns the 16 bits of the addressed half.
- R3: The input register shows a new pin level on the third rising clock edge after the pin changes, and not earlier.
- R4: A low-to-high change on pin p whose rising-mask bit p is set raises the interrupt and sets status to exactly 1 << p.
- R5: A high-to-low change on pin p whose falling-mask bit p is set raises the interrupt and sets status to exactly 1 << p.
- R6: A pin change whose matching mask bit is clear leaves the interrupt and the status unchanged.
- R7: A new event replaces the whole status with its own pin bit; writes to the status offsets have no effect, and no write clears the status.
- R8: The interrupt stays high until a cycle with the acknowledge input high clears it; the acknowledge leaves the status unchanged, and an event in the same cycle as the acknowledge keeps the interrupt high.
- R9: The output-enable register keeps three bits: a write to 0x508 stores data bits [2:0], a read of 0x508 returns them with bits [15:3] zero, and 0x008 reads zero and ignores writes.
- R10: With o = output bits [18:16] and e = output-enable bits [2:0], the backlight level is 0 for o=0,e=7; 1 for o=2,e=0; 2 for o=2,e=1; 3 for o=4,e=0; 4 for o=1,e=6; 5 for o=2,e=5; 6 for o=4,e=3; and 7 for every other pair.
- R11: The I2C data line equals output bit 29 and the clock line equals output bit 30; they change only on a write to the output high half.
- R12: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data for the addressed half |
| reg_rdata | output | 16 | Read data of the addressed half, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| irq_ack | input | 1 | Clears the interrupt level |
| irq | output | 1 | Interrupt level |
| bl_level | output | 3 | Decoded backlight level |
| i2c_sda | output | 1 | Bit-banged I2C data line |
| i2c_scl | output | 1 | Bit-banged I2C clock line |

## Verification
The acknowledge and a qualified pin edge can reach the interrupt register on the same clock edge. The bench changes a masked pin, then raises the acknowledge for exactly the cycle in which the synchronised edge is detected, while the interrupt is still high from an earlier event. It judges the result by the interrupt staying high and the status holding the new pin, followed by a plain acknowledge that clears the interrupt but leaves the status in place.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;

   localparam int OFS_OE   = 'h008;
   localparam int OFS_OUT  = 'h00C;
   localparam int OFS_IN   = 'h010;
   localparam int OFS_FALL = 'h014;
   localparam int OFS_RISE = 'h018;
   localparam int OFS_STAT = 'h020;

   localparam int BL_LSB   = 16;
   localparam int SDA_BIT  = 29;
   localparam int SCL_BIT  = 30;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_OE, SEL_OUT, SEL_IN, SEL_FALL, SEL_RISE, SEL_STAT
   } reg_sel_e;

   // Fixed backlight code table: key is {output[18:16], oe[2:0]}
   function automatic logic [2:0] bl_lookup(input logic [2:0] o, input logic [2:0] e);
      case ({o, e})
         6'o07:   return 3'd0;
         6'o20:   return 3'd1;
         6'o21:   return 3'd2;
         6'o40:   return 3'd3;
         6'o16:   return 3'd4;
         6'o25:   return 3'd5;
         6'o43:   return 3'd6;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/gpio_half_reg.sv
module gpio_half_reg #(
   parameter int HALF_W = 16,
   parameter int HALVES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(HALVES)-1:0]  wr_half,
   input  logic [HALF_W-1:0]          wdata,
   output logic [HALF_W*HALVES-1:0]   q
);

   if (HALVES < 2) begin : g_bad_halves
      $error("gpio_half_reg needs at least two halves");
   end

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[h*HALF_W +: HALF_W] <= '0;
         else if (wr_en && (int'(wr_half) == h))
            q[h*HALF_W +: HALF_W] <= wdata;
      end

      // R2
      half_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (int'(wr_half) == h)) |=> (q[h*HALF_W +: HALF_W] == $past(wdata)));

      // R2
      half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (int'(wr_half) == h)) |=> $stable(q[h*HALF_W +: HALF_W]));
   end

endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] rise_mask,
   input  logic [NUM_PINS-1:0] fall_mask,
   input  logic                ack,
   output logic [NUM_PINS-1:0] in_state,
   output logic [NUM_PINS-1:0] status,
   output logic                irq
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_sync_edge needs two or more synchroniser stages");
   end

   logic [NUM_PINS-1:0] stg [SYNC_STAGES];
   logic [NUM_PINS-1:0] lvl, chg, qual, pick;
   logic                hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '1;
      end else begin
         stg[0] <= pin_in;
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign lvl  = stg[SYNC_STAGES-1];
   assign chg  = lvl ^ in_state;
   assign qual = chg & ((lvl & rise_mask) | (~lvl & fall_mask));
   // lowest qualifying pin wins when several change together
   assign pick = qual & (~qual + NUM_PINS'(1));
   assign hit  = |qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_state <= '1;
         status   <= '0;
         irq      <= 1'b0;
      end else begin
         in_state <= lvl;
         if (hit) begin
            status <= pick;
            irq    <= 1'b1;
         end else if (ack) begin
            irq    <= 1'b0;
         end
      end
   end

   // R7
   status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status));

   // R7
   status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(status));

   // R6
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !hit) |=> !irq);

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !hit) |=> !irq);

   // R8
   ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && hit) |=> irq);

endmodule

// File: rtl/gpio_bl_decode.sv
module gpio_bl_decode
   import gpio_split_pkg::*;
#(
   parameter bit BL_DECODE = 1'b1
) (
   input  logic [2:0] out_bits,
   input  logic [2:0] oe_bits,
   output logic [2:0] level
);

   if (BL_DECODE) begin : g_table
      assign level = bl_lookup(out_bits, oe_bits);
   end else begin : g_full
      logic [5:0] unused_key;
      assign unused_key = {out_bits, oe_bits};
      assign level = 3'd7;
   end

endmodule

// File: rtl/gpio_split_edge.sv
module gpio_split_edge
   import gpio_split_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 12,
   parameter int HI_STRIDE   = 'h500,
   parameter int SYNC_STAGES = 2,
   parameter bit BL_DECODE   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_wr,
   input  logic [NUM_PINS/2-1:0] reg_wdata,
   output logic [NUM_PINS/2-1:0] reg_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   input  logic                  irq_ack,
   output logic                  irq,
   output logic [2:0]            bl_level,
   output logic                  i2c_sda,
   output logic                  i2c_scl
);

   localparam int HALF_W = NUM_PINS / 2;
   localparam int HALVES = 2;
   localparam int OE_W   = 3;

   if ((NUM_PINS % 2) != 0 || NUM_PINS <= SCL_BIT) begin : g_bad_pins
      $error("gpio_split_edge needs an even pin count above the I2C clock bit");
   end
   if (HI_STRIDE <= OFS_STAT || HI_STRIDE + OFS_STAT >= (1 << ADDR_W)) begin : g_bad_stride
      $error("gpio_split_edge high window does not fit the address width");
   end

   reg_sel_e            sel;
   logic                is_hi;
   logic [ADDR_W-1:0]   off;
   logic [NUM_PINS-1:0] out_q, fall_q, rise_q, in_state, status;
   logic [OE_W-1:0]     oe_q;

   // ---------------- address decode ----------------
   always_comb begin
      is_hi = (reg_addr >= ADDR_W'(HI_STRIDE));
      off   = is_hi ? reg_addr - ADDR_W'(HI_STRIDE) : reg_addr;
      case (off)
         ADDR_W'(OFS_OE):   sel = SEL_OE;
         ADDR_W'(OFS_OUT):  sel = SEL_OUT;
         ADDR_W'(OFS_IN):   sel = SEL_IN;
         ADDR_W'(OFS_FALL): sel = SEL_FALL;
         ADDR_W'(OFS_RISE): sel = SEL_RISE;
         ADDR_W'(OFS_STAT): sel = SEL_STAT;
         default:           sel = SEL_NONE;
      endcase
   end

   // ---------------- split registers ----------------
   gpio_half_reg #(.HALF_W(HALF_W), .HALVES(HALVES)) i_out_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel == SEL_OUT),
      .wr_half(is_hi), .wdata(reg_wdata), .q(out_q));

   gpio_half_reg #(.HALF_W(HALF_W), .HALVES(HALVES)) i_fall_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel == SEL_FALL),
      .wr_half(is_hi), .wdata(reg_wdata), .q(fall_q));

   gpio_half_reg #(.HALF_W(HALF_W), .HALVES(HALVES)) i_rise_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel == SEL_RISE),
      .wr_half(is_hi), .wdata(reg_wdata), .q(rise_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         oe_q <= '0;
      else if (reg_wr && sel == SEL_OE && is_hi)
         oe_q <= reg_wdata[OE_W-1:0];
   end

   // ---------------- pins and interrupt ----------------
   gpio_sync_edge #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .rise_mask(rise_q), .fall_mask(fall_q), .ack(irq_ack),
      .in_state(in_state), .status(status), .irq(irq));

   // ---------------- derived outputs ----------------
   gpio_bl_decode #(.BL_DECODE(BL_DECODE)) i_bl (
      .out_bits(out_q[BL_LSB +: 3]), .oe_bits(oe_q), .level(bl_level));

   assign i2c_sda = out_q[SDA_BIT];
   assign i2c_scl = out_q[SCL_BIT];

   // ---------------- read mux ----------------
   function automatic logic [HALF_W-1:0] half_of(input logic [NUM_PINS-1:0] v, input logic hi);
      return hi ? v[NUM_PINS-1:HALF_W] : v[HALF_W-1:0];
   endfunction

   always_comb begin
      case (sel)
         SEL_OE:   reg_rdata = is_hi ? HALF_W'(oe_q) : '0;
         SEL_OUT:  reg_rdata = half_of(out_q, is_hi);
         SEL_IN:   reg_rdata = half_of(in_state, is_hi);
         SEL_FALL: reg_rdata = half_of(fall_q, is_hi);
         SEL_RISE: reg_rdata = half_of(rise_q, is_hi);
         SEL_STAT: reg_rdata = half_of(status, is_hi);
         default:  reg_rdata = '0;
      endcase
   end

   // R11
   i2c_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && sel == SEL_OUT && is_hi) |=> ($stable(i2c_sda) && $stable(i2c_scl)));

   // R9
   oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_OE) |-> (reg_rdata[HALF_W-1:OE_W] == '0));

   // R12
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

// File: tb/test_gpio_split_edge.sv
module test_gpio_split_edge;

   localparam int A_OE_LO = 'h008, A_OE_HI = 'h508;
   localparam int A_OUT_LO = 'h00C, A_OUT_HI = 'h50C;
   localparam int A_IN_LO = 'h010, A_IN_HI = 'h510;
   localparam int A_FALL_LO = 'h014, A_FALL_HI = 'h514;
   localparam int A_RISE_LO = 'h018, A_RISE_HI = 'h518;
   localparam int A_STAT_LO = 'h020, A_STAT_HI = 'h520;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [31:0] pin_in = '1;
   logic        irq_ack = 1'b0;
   logic        irq;
   logic [2:0]  bl_level;
   logic        i2c_sda, i2c_scl;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_split_edge i_gpio_split_edge (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .irq_ack(irq_ack), .irq(irq), .bl_level(bl_level),
      .i2c_sda(i2c_sda), .i2c_scl(i2c_scl));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = 12'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = 12'(a);
      #1 d = reg_rdata;
   endtask

   task automatic rd32(input int lo, output logic [31:0] d);
      logic [15:0] l, h;
      rd(lo, l);
      rd(lo + 'h500, h);
      d = {h, l};
   endtask

   task automatic wr32(input int lo, input logic [31:0] d);
      wr(lo, d[15:0]);
      wr(lo + 'h500, d[31:16]);
   endtask

   task automatic set_pin(input int p, input logic v);
      @(negedge clk);
      pin_in[p] = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic ack_pulse();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   function automatic logic [2:0] ref_level(input logic [2:0] o, input logic [2:0] e);
      if (o == 0 && e == 7) return 0;
      if (o == 2 && e == 0) return 1;
      if (o == 2 && e == 1) return 2;
      if (o == 4 && e == 0) return 3;
      if (o == 1 && e == 6) return 4;
      if (o == 2 && e == 5) return 5;
      if (o == 4 && e == 3) return 6;
      return 7;
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd32(A_IN_LO, v);   check("R1 input", v, 32'hFFFF_FFFF);
      rd32(A_OUT_LO, v);  check("R1 output", v, 0);
      rd32(A_RISE_LO, v); check("R1 rise mask", v, 0);
      rd32(A_FALL_LO, v); check("R1 fall mask", v, 0);
      rd32(A_STAT_LO, v); check("R1 status", v, 0);
      check("R1 irq", irq, 0);
      check("R1 backlight", bl_level, 7);
   endtask

   task automatic t_halves();
      logic [31:0] v;
      wr(A_OUT_LO, 16'hA5C3);
      rd32(A_OUT_LO, v); check("R2 low write", v, 32'h0000_A5C3);
      wr(A_OUT_HI, 16'h0F1E);
      rd32(A_OUT_LO, v); check("R2 high write", v, 32'h0F1E_A5C3);
      wr(A_OUT_LO, 16'h0001);
      rd32(A_OUT_LO, v); check("R2 low keeps high", v, 32'h0F1E_0001);
      wr32(A_OUT_LO, 0);
      wr(A_FALL_HI, 16'h8001);
      rd32(A_FALL_LO, v); check("R2 fall mask halves", v, 32'h8001_0000);
      wr32(A_FALL_LO, 0);
   endtask

   task automatic t_input_sync();
      logic [15:0] d;
      rd(A_IN_LO, d);
      pin_in[12] = 1'b0;            // change right after a negedge
      @(negedge clk); @(negedge clk);
      check("R3 input not early", reg_rdata, 16'hFFFF);
      @(negedge clk);
      check("R3 input after sync", reg_rdata, 16'hEFFF);
      set_pin(12, 1);
      rd(A_IN_LO, d); check("R3 input restored", d, 16'hFFFF);
      check("R6 no mask no irq", irq, 0);
   endtask

   task automatic t_rise();
      logic [31:0] v;
      wr32(A_RISE_LO, 32'h0000_0020);
      set_pin(5, 0);
      check("R6 falling with rise mask only", irq, 0);
      set_pin(5, 1);
      check("R4 irq on rise", irq, 1);
      rd32(A_STAT_LO, v); check("R4 status pin5", v, 32'h0000_0020);
      ack_pulse();
      check("R8 ack clears", irq, 0);
   endtask

   task automatic t_fall();
      logic [31:0] v;
      wr32(A_FALL_LO, 32'h0010_0000);
      set_pin(20, 0);
      check("R5 irq on fall", irq, 1);
      rd32(A_STAT_LO, v); check("R5 status pin20", v, 32'h0010_0000);
      ack_pulse();
   endtask

   task automatic t_masked();
      logic [31:0] v;
      set_pin(9, 0);
      check("R6 masked fall irq", irq, 0);
      set_pin(20, 1);
      check("R6 unmasked polarity irq", irq, 0);
      rd32(A_STAT_LO, v); check("R6 status unchanged", v, 32'h0010_0000);
      set_pin(9, 1);
   endtask

   task automatic t_replace();
      logic [31:0] v;
      wr32(A_RISE_LO, 32'h0800_0020);
      set_pin(27, 0);
      check("R6 pin27 fall masked", irq, 0);
      set_pin(27, 1);
      rd32(A_STAT_LO, v); check("R7 status replaced", v, 32'h0800_0000);
      wr(A_STAT_LO, 16'hFFFF);
      wr(A_STAT_HI, 16'h0000);
      rd32(A_STAT_LO, v); check("R7 status write ignored", v, 32'h0800_0000);
      check("R8 irq held without ack", irq, 1);
   endtask

   task automatic t_ack_collision();
      logic [31:0] v;
      wr32(A_FALL_LO, 32'h0010_0008);
      @(negedge clk); pin_in[3] = 1'b0;
      @(negedge clk);
      @(negedge clk); irq_ack = 1'b1;      // high across the detecting edge
      @(negedge clk); irq_ack = 1'b0;
      check("R8 edge wins over ack", irq, 1);
      rd32(A_STAT_LO, v); check("R8 status from collision", v, 32'h0000_0008);
      ack_pulse();
      check("R8 plain ack clears", irq, 0);
      rd32(A_STAT_LO, v); check("R8 ack keeps status", v, 32'h0000_0008);
      set_pin(3, 1);
   endtask

   task automatic t_oe();
      logic [15:0] d;
      wr(A_OE_HI, 16'hFFFD);
      rd(A_OE_HI, d); check("R9 oe high three bits", d, 16'h0005);
      wr(A_OE_LO, 16'hFFFF);
      rd(A_OE_LO, d); check("R9 oe low reads zero", d, 0);
      rd(A_OE_HI, d); check("R9 oe low write ignored", d, 16'h0005);
   endtask

   task automatic t_backlight();
      for (int o = 0; o < 8; o++) begin
         for (int e = 0; e < 8; e++) begin
            wr(A_OUT_HI, 16'(o));
            wr(A_OE_HI, 16'(e));
            check($sformatf("R10 level o=%0d e=%0d", o, e), bl_level,
                  ref_level(3'(o), 3'(e)));
         end
      end
   endtask

   task automatic t_i2c();
      wr(A_OUT_HI, 16'h2000);
      check("R11 sda high", {i2c_scl, i2c_sda}, 2'b01);
      wr(A_OUT_HI, 16'h4000);
      check("R11 scl high", {i2c_scl, i2c_sda}, 2'b10);
      wr(A_OUT_LO, 16'hFFFF);
      check("R11 low write no effect", {i2c_scl, i2c_sda}, 2'b10);
      wr32(A_OUT_LO, 0);
   endtask

   task automatic t_unmapped();
      logic [15:0] d;
      logic [31:0] v;
      wr(A_OUT_LO, 16'h1234);
      wr('h024, 16'hFFFF);
      wr('h300, 16'hFFFF);
      rd('h024, d); check("R12 unmapped read", d, 0);
      rd('h51C, d); check("R12 unmapped high read", d, 0);
      rd32(A_OUT_LO, v); check("R12 output untouched", v, 32'h0000_1234);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_halves();
      t_input_sync();
      t_rise();
      t_fall();
      t_masked();
      t_replace();
      t_ack_collision();
      t_oe();
      t_backlight();
      t_i2c();
      t_unmapped();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule